// File: doc/BRIEF.md
# Edge-Capturing GPIO Bank

A single bank of general-purpose pins with a small word-addressed register port. Software decides, per pin, whether the pin is driven or sensed. Driven levels are changed only by writing bit masks to a set register or a clear register, so one pin can be updated without a read-modify-write and without disturbing its neighbours. Every pin is brought into the bank clock domain through a two-stage synchronizer, and the synchronized level can be read back whether the pin is sensed or driven.

Each pin can capture a rising transition, a falling transition, or both, into a sticky status bit. The two per-pin edge-enable masks are also changed only through set and clear registers. Software clears status bits by writing ones to the status register. The whole status vector is presented on a port, so an interrupt controller can OR or mask it as it likes.

Top module: `gpio_edge_bank`

## Requirements
- R1: Word offsets decode as 0 direction, 1 output level, 2 output-set, 3 output-clear, 4 pin level, 5 rise-enable-set, 6 rise-enable-clear, 7 fall-enable-set, 8 fall-enable-clear, 9 status; offsets 10 to 15 read as zero, and writes to them change nothing.
- R2: A direction bit of 1 makes the pin sensed and a 0 makes it driven; `pins_oe` is the bitwise inverse of the direction register, which reads back at offset 0.
- R3: Writing a mask to offset 2 sets the matching output bits, writing a mask to offset 3 clears them, and zero bits in either mask leave the other pins as they were; `pins_out` shows the output register.
- R4: Writes to offset 1 (output level) and offset 4 (pin level) have no effect.
- R5: Offset 4 returns the pin levels after a two-flop synchronizer: a change on `pins_in` is visible after the second rising clock edge and not after the first, whatever the pin's direction.
- R6: With its rise enable on, a 0-to-1 change on a pin sets its status bit after the third rising clock edge and not earlier.
- R7: With its fall enable on, a 1-to-0 change on a pin sets its status bit after the third rising clock edge; with that enable off the change sets nothing.
- R8: With both enables on, either edge sets the status bit; with both off, no edge does.
- R9: Writing ones to offset 9 clears those status bits; zero bits in the write leave status untouched.
- R10: An enabled edge that would set a status bit on the same clock edge that a clear write hits that bit wins, and the bit stays set.
- R11: After reset every direction bit is 1, output, edge enables and status are zero, and the set/clear offsets 2, 3, 5, 6, 7, 8 always read as zero.
- R12: `rd_data` reflects the register at `addr` in the same cycle, with no read latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 4 | Word offset for read and write |
| wr_data | input | 32 | Write data / bit mask |
| rd_data | output | 32 | Read data for the word at `addr` |
| pins_in | input | 32 | Raw pad levels, asynchronous |
| pins_out | output | 32 | Pad drive levels |
| pins_oe | output | 32 | Pad output enables, 1 = drive |
| irq_status | output | 32 | Sticky per-pin edge status |

## Verification
The status-origin and clear properties assume that a status bit can only rise in a cycle where the edge detector flagged that pin, and they assume reset is held for at least two clocks so the synchronizer and edge history start at zero with the pins low. The stimulus holds `pins_in` at zero through reset, changes pins only at falling clock edges, and waits for each edge's capture before issuing the next clear, except in the one deliberately coincident case. Sweeps walk every pin through every combination of the two edge enables, with expected status computed as a single-bit mask in the bench.

// File: rtl/gpio_edge_pkg.sv
// Package: word offsets of the register window and shared widths.
// Assumes a word-addressed port; offsets index 32-bit words.
package gpio_edge_pkg;
    localparam int unsigned OFF_DIR     = 0;
    localparam int unsigned OFF_OUT     = 1;
    localparam int unsigned OFF_OUTSET  = 2;
    localparam int unsigned OFF_OUTCLR  = 3;
    localparam int unsigned OFF_PINS    = 4;
    localparam int unsigned OFF_RISESET = 5;
    localparam int unsigned OFF_RISECLR = 6;
    localparam int unsigned OFF_FALLSET = 7;
    localparam int unsigned OFF_FALLCLR = 8;
    localparam int unsigned OFF_STAT    = 9;
    localparam int unsigned NUM_REGS    = 10;

    // One-hot write strobes produced by the decoder.
    typedef struct packed {
        logic dir;
        logic outset;
        logic outclr;
        logic riseset;
        logic riseclr;
        logic fallset;
        logic fallclr;
        logic stat;
    } wr_strobe_t;
endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage level synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; no bus coherency across bits is implied.
module gpio_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the pin levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
// Module: per-bit rising and falling transition detector.
// Assumes the input is already synchronous; outputs pulse for one cycle.
module gpio_edge_detect #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] last_q;

    // Remember the level seen in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= level;
    end

    // Compare present and previous level, per bit.
    genvar g;
    generate
        for (g = 0; g < int'(W); g++) begin : g_bit
            assign rise[g] =  level[g] & ~last_q[g];
            assign fall[g] = ~level[g] &  last_q[g];
        end
    endgenerate
endmodule

// File: rtl/gpio_addr_decode.sv
// Module: turns a write request into one-hot register strobes.
// Assumes offsets outside the map produce no strobe.
module gpio_addr_decode
    import gpio_edge_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output wr_strobe_t        stb
);
    // Compare the offset against each writable register.
    always_comb begin
        stb         = '0;
        stb.dir     = wr_en && (addr == ADDR_W'(OFF_DIR));
        stb.outset  = wr_en && (addr == ADDR_W'(OFF_OUTSET));
        stb.outclr  = wr_en && (addr == ADDR_W'(OFF_OUTCLR));
        stb.riseset = wr_en && (addr == ADDR_W'(OFF_RISESET));
        stb.riseclr = wr_en && (addr == ADDR_W'(OFF_RISECLR));
        stb.fallset = wr_en && (addr == ADDR_W'(OFF_FALLSET));
        stb.fallclr = wr_en && (addr == ADDR_W'(OFF_FALLCLR));
        stb.stat    = wr_en && (addr == ADDR_W'(OFF_STAT));
    end
endmodule

// File: rtl/gpio_ctrl_regs.sv
// Module: direction, output, edge-enable and sticky status registers.
// Assumes rise/fall are single-cycle pulses from the edge detector.
module gpio_ctrl_regs
    import gpio_edge_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  wr_strobe_t   stb,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] out_q,
    output logic [W-1:0] stat_q
);
    logic [W-1:0] rise_en_q;
    logic [W-1:0] fall_en_q;
    logic [W-1:0] stat_clr;
    logic [W-1:0] stat_hit;

    // Direction register: plain write, resets to all sensed.
    always_ff @(posedge clk) begin
        if (!rst_n)       dir_q <= '1;
        else if (stb.dir) dir_q <= wr_data;
    end

    // Output level: set and clear masks only.
    always_ff @(posedge clk) begin
        if (!rst_n)          out_q <= '0;
        else if (stb.outset) out_q <= out_q | wr_data;
        else if (stb.outclr) out_q <= out_q & ~wr_data;
    end

    // Rising-edge enable mask: set and clear masks only.
    always_ff @(posedge clk) begin
        if (!rst_n)           rise_en_q <= '0;
        else if (stb.riseset) rise_en_q <= rise_en_q | wr_data;
        else if (stb.riseclr) rise_en_q <= rise_en_q & ~wr_data;
    end

    // Falling-edge enable mask: set and clear masks only.
    always_ff @(posedge clk) begin
        if (!rst_n)           fall_en_q <= '0;
        else if (stb.fallset) fall_en_q <= fall_en_q | wr_data;
        else if (stb.fallclr) fall_en_q <= fall_en_q & ~wr_data;
    end

    // Form the clear mask and the enabled edge hits for status.
    always_comb begin
        stat_clr = stb.stat ? wr_data : '0;
        stat_hit = (rise & rise_en_q) | (fall & fall_en_q);
    end

    // Sticky status: a new hit outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | stat_hit;
    end
endmodule

// File: rtl/gpio_edge_bank.sv
// Module: top of one GPIO bank with edge-capture status.
// Assumes a single-cycle register port; reads are combinational.
module gpio_edge_bank
    import gpio_edge_pkg::*;
#(
    parameter int unsigned NPINS   = 32,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned SYNC_ST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wr_data,
    output logic [NPINS-1:0]  rd_data,
    input  logic [NPINS-1:0]  pins_in,
    output logic [NPINS-1:0]  pins_out,
    output logic [NPINS-1:0]  pins_oe,
    output logic [NPINS-1:0]  irq_status
);
    wr_strobe_t       stb_w;
    logic [NPINS-1:0] lvl_w;
    logic [NPINS-1:0] rise_w;
    logic [NPINS-1:0] fall_w;
    logic [NPINS-1:0] dir_w;
    logic [NPINS-1:0] out_w;
    logic [NPINS-1:0] stat_w;

    gpio_sync #(.W(NPINS), .STAGES(SYNC_ST)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_in),
        .sync_out (lvl_w)
    );

    gpio_edge_detect #(.W(NPINS)) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .level (lvl_w),
        .rise  (rise_w),
        .fall  (fall_w)
    );

    gpio_addr_decode #(.ADDR_W(ADDR_W)) dec_i (
        .wr_en (wr_en),
        .addr  (addr),
        .stb   (stb_w)
    );

    gpio_ctrl_regs #(.W(NPINS)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (stb_w),
        .wr_data (wr_data),
        .rise    (rise_w),
        .fall    (fall_w),
        .dir_q   (dir_w),
        .out_q   (out_w),
        .stat_q  (stat_w)
    );

    // Read mux: readable registers by offset, everything else zero.
    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(OFF_DIR))  rd_data = dir_w;
        if (addr == ADDR_W'(OFF_OUT))  rd_data = out_w;
        if (addr == ADDR_W'(OFF_PINS)) rd_data = lvl_w;
        if (addr == ADDR_W'(OFF_STAT)) rd_data = stat_w;
    end

    assign pins_out   = out_w;
    assign pins_oe    = ~dir_w;
    assign irq_status = stat_w;
endmodule

// File: rtl/gpio_edge_bank_chk.sv
// Module: property checker for gpio_edge_bank, attached by bind.
// Assumes reset is held for at least two clocks.
module gpio_edge_bank_chk
    import gpio_edge_pkg::*;
#(
    parameter int unsigned W      = 32,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [W-1:0]      wr_data,
    input logic [W-1:0]      rd_data,
    input logic [W-1:0]      pins_out,
    input logic [W-1:0]      pins_oe,
    input logic [W-1:0]      irq_status,
    input logic [W-1:0]      rise_w,
    input logic [W-1:0]      fall_w
);
    // R2
    oe_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(OFF_DIR)) |-> (rd_data == ~pins_oe));

    // R3
    outset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_OUTSET)) |=>
        ((pins_out & $past(wr_data)) == $past(wr_data)));

    // R3
    outclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_OUTCLR)) |=>
        ((pins_out & $past(wr_data)) == '0));

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || (addr != ADDR_W'(OFF_OUTSET) && addr != ADDR_W'(OFF_OUTCLR)))
        |=> $stable(pins_out));

    // R6
    stat_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_status & ~$past(irq_status) & ~$past(rise_w | fall_w)) == '0));

    // R9
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_STAT)) |=>
        ((irq_status & $past(wr_data) & ~$past(rise_w | fall_w)) == '0));

    // R9
    stat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_STAT)) |=>
        ((irq_status & $past(irq_status & ~wr_data)) == $past(irq_status & ~wr_data)));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.W(NPINS), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .pins_out   (pins_out),
    .pins_oe    (pins_oe),
    .irq_status (irq_status),
    .rise_w     (rise_w),
    .fall_w     (fall_w)
);

// File: tb/gpio_edge_bank_tb.sv
// Bench: sweeps every pin through all edge-enable combinations.
module gpio_edge_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] pins_in = '0;
    logic [31:0] pins_out;
    logic [31:0] pins_oe;
    logic [31:0] irq_status;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    gpio_edge_bank dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pins_in(pins_in),
        .pins_out(pins_out), .pins_oe(pins_oe), .irq_status(irq_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        addr = 4'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input int a, input logic [31:0] exp);
        addr = 4'(a);
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] out_m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state, R2 direction
        rd("R11 dir", 0, 32'hFFFF_FFFF);
        chk("R2 oe reset", pins_oe, 32'h0);
        chk("R11 out", pins_out, 32'h0);
        chk("R11 status", irq_status, 32'h0);
        for (int a = 2; a <= 8; a++) if (a != 4) rd("R11 set/clr read zero", a, 32'h0);
        rd("R5 pins reset", 4, 32'h0);

        // R2 direction and enables
        wr(0, 32'h0000_FFFF);
        rd("R2 dir readback", 0, 32'h0000_FFFF);
        chk("R2 oe inverse", pins_oe, 32'hFFFF_0000);

        // R3 set/clear sweep
        out_m = '0;
        for (int i = 0; i < 32; i++) begin
            wr(2, 32'(1) << i);
            out_m |= 32'(1) << i;
            chk("R3 set", pins_out, out_m);
        end
        for (int i = 0; i < 32; i += 2) begin
            wr(3, 32'(1) << i);
            out_m &= ~(32'(1) << i);
            chk("R3 clear", pins_out, out_m);
        end
        rd("R12 out readback", 1, out_m);
        wr(2, 32'h0); chk("R3 zero set mask", pins_out, out_m);
        wr(3, 32'h0); chk("R3 zero clr mask", pins_out, out_m);
        // R4 writes to level registers ignored
        wr(1, 32'h0);
        chk("R4 out write ignored", pins_out, out_m);
        wr(4, 32'hFFFF_FFFF);
        rd("R4 pins write ignored", 4, 32'h0);
        // R1 unmapped offset
        wr(15, 32'hFFFF_FFFF);
        rd("R1 unmapped read", 15, 32'h0);
        rd("R1 dir untouched", 0, 32'h0000_FFFF);
        chk("R1 out untouched", pins_out, out_m);
        chk("R1 status untouched", irq_status, 32'h0);

        // R5 synchronizer latency, pins driven as outputs too
        pins_in = 32'hA5C3_0F96;
        idle(1);
        rd("R5 first edge still old", 4, 32'h0);
        idle(1);
        rd("R5 second edge new", 4, 32'hA5C3_0F96);
        chk("R7 fall disabled, no capture", irq_status, 32'h0);
        pins_in = 32'h0;
        idle(3);
        chk("R8 no enables, no capture", irq_status, 32'h0);

        // R6 R7 R8 all enable modes over all pins
        for (int mode = 0; mode < 4; mode++) begin
            wr(6, 32'hFFFF_FFFF);
            wr(8, 32'hFFFF_FFFF);
            if (mode[0]) wr(5, 32'hFFFF_FFFF);
            if (mode[1]) wr(7, 32'hFFFF_FFFF);
            for (int i = 0; i < 32; i++) begin
                logic [31:0] m;
                m = 32'(1) << i;
                pins_in = m;
                idle(2);
                chk("R6 not before third edge", irq_status, 32'h0);
                idle(1);
                chk(mode[0] ? "R6 rise captured" : "R8 rise ignored", irq_status, mode[0] ? m : 32'h0);
                if (mode == 1 && i == 7) begin
                    wr(9, ~m);
                    chk("R9 zero bits keep status", irq_status, m);
                end
                wr(9, 32'hFFFF_FFFF);
                chk("R9 clear", irq_status, 32'h0);
                pins_in = 32'h0;
                idle(3);
                chk(mode[1] ? "R7 fall captured" : "R7 fall ignored", irq_status, mode[1] ? m : 32'h0);
                rd("R12 status readback", 9, mode[1] ? m : 32'h0);
                wr(9, 32'hFFFF_FFFF);
            end
        end

        // R10 edge coincident with clear
        wr(8, 32'hFFFF_FFFF);
        wr(6, 32'hFFFF_FFFF);
        wr(5, 32'h0000_0020);
        pins_in = 32'h20;
        idle(3);
        chk("R10 first capture", irq_status, 32'h20);
        pins_in = 32'h0;
        idle(3);
        chk("R10 held over fall", irq_status, 32'h20);
        pins_in = 32'h20;
        idle(1);
        wr(9, 32'h20);
        chk("R10 edge beats clear", irq_status, 32'h20);
        wr(9, 32'h20);
        chk("R10 later clear", irq_status, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule